// File: doc/BRIEF.md
# Single-Drop 1-Wire Temperature Sequencer

This block runs the byte-level conversation with one temperature sensor on a 1-Wire bus. A separate bit-level bus engine handles the line timing. The sequencer hands that engine one command at a time (a bus reset, a byte to write, or a byte to read) and waits for the engine's completion strobe before it issues the next one.

Two jobs are supported. A measurement starts a conversion, waits out the conversion time, then reads back the sensor's nine-byte scratch memory and turns its first two bytes into a whole-degree temperature. An identity read fetches the sensor's eight-byte serial code. Both jobs check the returned block with the 1-Wire CRC-8. The result comes out with a one-cycle completion pulse and three flags: presence, CRC status and overall validity.

The conversion wait is counted in clock cycles. The count is derived from a clock-frequency parameter and a wait-length parameter in milliseconds. A testbench can shrink the wait by lowering the frequency parameter.

Top module: `ow_temp_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `valid`, `crcOk`, `present` and `busReq` are 0, `tempC` is 0 and `romCode` is 0.
- R2: Every bus command is a one-cycle `busReq` pulse carrying `busOp` (0 = bus reset, 1 = write `busWrByte`, 2 = read one byte). No new request is raised until the engine has pulsed `busDone` for the outstanding one.
- R3: A measurement issues, in this order: reset, write 0xCC, write 0x44, the conversion wait, reset, write 0xCC, write 0xBE, then nine reads.
- R4: The conversion wait lasts WAIT_CYC = CLK_HZ/1000*CONV_MS cycles. The second reset request is raised exactly WAIT_CYC+1 cycles after the cycle in which `busDone` completes the 0x44 write.
- R5: An identity read issues reset, write 0x33, then eight reads. The first byte read lands in `romCode[7:0]`, and byte i lands in bits 8i+7 down to 8i.
- R6: The CRC is the reflected CRC-8 (polynomial x^8+x^5+x^4+1, 0x8C in reflected form), starting from 0 and taking each byte least significant bit first. It runs over every byte read, including the final CRC byte. `crcOk` is 1 exactly when the result is 0 and presence was seen.
- R7: `tempC` (12 bits, two's complement) is the 16-bit word {byte 1, byte 0} of the scratch memory, arithmetically shifted right by 4. Readings below zero keep their sign.
- R8: If the first reset reports no presence, the job stops at once with no further bus requests. It completes with `present`, `crcOk` and `valid` all 0.
- R9: `done` is a one-cycle pulse raised two cycles after the cycle in which the final `busDone` of the job is seen. In that cycle the flags are updated, with `valid` = `present` AND `crcOk`. The flags then hold until the next completion.
- R10: `startMeas` and `startId` are sampled only while `busy` is 0, and a start sets `busy` on the next cycle. Starts while busy are ignored. If both are raised together, a measurement runs.
- R11: `tempC` changes only at the completion of a measurement that saw presence. `romCode` changes only at the completion of an identity read that saw presence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startMeas | input | 1 | Start a temperature measurement (idle only) |
| startId | input | 1 | Start an identity read (idle only) |
| busReq | output | 1 | One-cycle command request to the bit engine |
| busOp | output | 2 | Command: 0 reset, 1 write, 2 read |
| busWrByte | output | 8 | Byte to write for a write command |
| busDone | input | 1 | Engine completion strobe for the outstanding command |
| busRdByte | input | 8 | Byte returned by a read command, valid with busDone |
| busPresence | input | 1 | Presence seen on a reset command, valid with busDone |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle job completion pulse |
| valid | output | 1 | Last job saw presence and a good CRC |
| crcOk | output | 1 | Last job's CRC check left zero |
| present | output | 1 | Last job saw a presence pulse |
| tempC | output | 12 | Signed whole-degree temperature |
| romCode | output | 64 | Identity code, first byte in the low bits |

## Verification
Some properties are checked by the embedded assertions on every clock: requests last one cycle, completion lasts one cycle, and an idle start is followed at once by a reset request. The assertions also check that a missing presence pulse sends the controller straight to completion, that the validity flag implies both presence and a good CRC, and that a job start clears the CRC and byte count. The exact command order, the length of the conversion wait, the byte placement in the identity code and the sign handling of the temperature are shown only by the bench scenarios. So are the rejection of bad CRCs and the ignoring of starts while busy, using a modelled bus engine that returns chosen byte streams.

// File: rtl/ows_pkg.sv
package ows_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } busOpE;

  localparam logic [7:0] CMD_SKIP_ADDR    = 8'hCC;
  localparam logic [7:0] CMD_READ_ID      = 8'h33;
  localparam logic [7:0] CMD_CONVERT      = 8'h44;
  localparam logic [7:0] CMD_READ_SCRATCH = 8'hBE;
  localparam logic [7:0] CRC_POLY_REFL    = 8'h8C;

  localparam int SCRATCH_BYTES = 9;
  localparam int ID_BYTES      = 8;
  localparam int CNT_W         = $clog2(SCRATCH_BYTES + 1);

  typedef struct packed {
    logic clear;     // new job: clear CRC, byte count, presence
    logic presLatch; // first reset finished: keep presence
    logic capture;   // a read byte has arrived
    logic timerRun;  // conversion wait in progress
    logic finish;    // latch results
    logic finMeas;   // job kind at finish
  } dpStrobeT;
endpackage

// File: rtl/ows_ctrl.sv
module ows_ctrl
  import ows_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startMeas,
  input  logic             startId,
  input  logic             busDone,
  input  logic             busPresence,
  input  logic             timerDone,
  input  logic [CNT_W-1:0] rdCount,
  output logic             busReq,
  output logic [1:0]       busOp,
  output logic [7:0]       busWrByte,
  output logic             busy,
  output logic             done,
  output dpStrobeT         strb
);
  typedef enum logic [3:0] {
    S_IDLE, S_RST1, S_ROMCMD, S_FUNC, S_WAIT,
    S_RST2, S_SKIP2, S_RDSP, S_READ, S_FIN
  } stateE;

  stateE state, stateNext;
  logic  isMeas, pending, doneQ, stepState, stepDone, lastByte;
  busOpE opSel;

  always_comb begin
    stepState = (state == S_RST1) || (state == S_ROMCMD) || (state == S_FUNC) ||
                (state == S_RST2) || (state == S_SKIP2) || (state == S_RDSP) ||
                (state == S_READ);
    opSel     = OP_RESET;
    busWrByte = 8'h00;
    case (state)
      S_ROMCMD: begin opSel = OP_WRITE; busWrByte = isMeas ? CMD_SKIP_ADDR : CMD_READ_ID; end
      S_FUNC:   begin opSel = OP_WRITE; busWrByte = CMD_CONVERT; end
      S_SKIP2:  begin opSel = OP_WRITE; busWrByte = CMD_SKIP_ADDR; end
      S_RDSP:   begin opSel = OP_WRITE; busWrByte = CMD_READ_SCRATCH; end
      S_READ:   opSel = OP_READ;
      default:  ;
    endcase
  end

  assign busOp    = opSel;
  assign busReq   = stepState && !pending;
  assign stepDone = pending && busDone;
  assign lastByte = rdCount == (isMeas ? CNT_W'(SCRATCH_BYTES - 1) : CNT_W'(ID_BYTES - 1));
  assign busy     = state != S_IDLE;
  assign done     = doneQ;

  always_comb begin
    strb.clear     = (state == S_IDLE) && (startMeas || startId);
    strb.presLatch = (state == S_RST1) && stepDone;
    strb.capture   = (state == S_READ) && stepDone;
    strb.timerRun  = state == S_WAIT;
    strb.finish    = state == S_FIN;
    strb.finMeas   = isMeas;
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:   if (startMeas || startId) stateNext = S_RST1;
      S_RST1:   if (stepDone) stateNext = busPresence ? S_ROMCMD : S_FIN;
      S_ROMCMD: if (stepDone) stateNext = isMeas ? S_FUNC : S_READ;
      S_FUNC:   if (stepDone) stateNext = S_WAIT;
      S_WAIT:   if (timerDone) stateNext = S_RST2;
      S_RST2:   if (stepDone) stateNext = S_SKIP2;
      S_SKIP2:  if (stepDone) stateNext = S_RDSP;
      S_RDSP:   if (stepDone) stateNext = S_READ;
      S_READ:   if (stepDone && lastByte) stateNext = S_FIN;
      S_FIN:    stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isMeas  <= 1'b0;
      pending <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= state == S_FIN;
      if (state == S_IDLE && (startMeas || startId)) isMeas <= startMeas;
      if (stepDone) pending <= 1'b0;
      else if (busReq) pending <= 1'b1;
    end
  end

  // R2: a request never lasts more than one cycle
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> !busReq);
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: an idle start is followed by a bus reset request
  a_r10_start_reset: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (startMeas || startId)) |=> (busReq && busOp == 2'd0));
  // R8: missing presence on the first reset ends the job
  a_r8_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RST1 && stepDone && !busPresence) |=> (state == S_FIN && !busReq));
endmodule

// File: rtl/ows_dpath.sv
module ows_dpath
  import ows_pkg::*;
#(
  parameter int WAIT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strb,
  input  logic             busPresence,
  input  logic [7:0]       busRdByte,
  output logic             timerDone,
  output logic [CNT_W-1:0] rdCount,
  output logic [11:0]      tempC,
  output logic [63:0]      romCode,
  output logic             crcOk,
  output logic             present,
  output logic             valid
);
  localparam int TW = $clog2(WAIT_CYC + 1);

  logic [7:0]       crc;
  logic [CNT_W-1:0] idx;
  logic [63:0]      rxBuf;
  logic             presReg;
  logic [TW-1:0]    timer;

  function automatic logic [7:0] crcStep(input logic [7:0] cIn, input logic [7:0] d);
    logic [7:0] c;
    logic       fb;
    c = cIn;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[7:1]};
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

  assign timerDone = timer == TW'(WAIT_CYC - 1);
  assign rdCount   = idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crc     <= '0;
      idx     <= '0;
      rxBuf   <= '0;
      presReg <= 1'b0;
      timer   <= '0;
      tempC   <= '0;
      romCode <= '0;
      crcOk   <= 1'b0;
      present <= 1'b0;
      valid   <= 1'b0;
    end else begin
      timer <= strb.timerRun ? timer + 1'b1 : '0;
      if (strb.clear) begin
        crc     <= '0;
        idx     <= '0;
        presReg <= 1'b0;
      end
      if (strb.presLatch) presReg <= busPresence;
      if (strb.capture) begin
        crc <= crcStep(crc, busRdByte);
        idx <= idx + 1'b1;
        if (idx < CNT_W'(ID_BYTES)) rxBuf[{idx[2:0], 3'b000} +: 8] <= busRdByte;
      end
      if (strb.finish) begin
        present <= presReg;
        crcOk   <= presReg && (crc == 8'h00);
        valid   <= presReg && (crc == 8'h00);
        // bits 15:4 of the raw word equal its arithmetic shift by 4, truncated to 12 bits
        if (presReg && strb.finMeas)  tempC   <= rxBuf[15:4];
        if (presReg && !strb.finMeas) romCode <= rxBuf;
      end
    end
  end

  // R9: validity implies both presence and a good CRC
  a_r9_valid_flags: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (present && crcOk));
  // R6: a new job starts the CRC from zero and the byte count from zero
  a_r6_crc_init: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (crc == 8'h00 && idx == '0));
endmodule

// File: rtl/ow_temp_sequencer.sv
module ow_temp_sequencer #(
  parameter int CLK_HZ  = 200_000_000,
  parameter int CONV_MS = 750
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startMeas,
  input  logic        startId,
  output logic        busReq,
  output logic [1:0]  busOp,
  output logic [7:0]  busWrByte,
  input  logic        busDone,
  input  logic [7:0]  busRdByte,
  input  logic        busPresence,
  output logic        busy,
  output logic        done,
  output logic        valid,
  output logic        crcOk,
  output logic        present,
  output logic [11:0] tempC,
  output logic [63:0] romCode
);
  localparam int WAIT_CYC = CLK_HZ / 1000 * CONV_MS;

  ows_pkg::dpStrobeT             strb;
  logic                          timerDone;
  logic [ows_pkg::CNT_W-1:0]     rdCount;

  ows_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startMeas(startMeas), .startId(startId),
    .busDone(busDone), .busPresence(busPresence), .timerDone(timerDone),
    .rdCount(rdCount), .busReq(busReq), .busOp(busOp), .busWrByte(busWrByte),
    .busy(busy), .done(done), .strb(strb)
  );

  ows_dpath #(.WAIT_CYC(WAIT_CYC)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busPresence(busPresence),
    .busRdByte(busRdByte), .timerDone(timerDone), .rdCount(rdCount),
    .tempC(tempC), .romCode(romCode), .crcOk(crcOk), .present(present),
    .valid(valid)
  );
endmodule

// File: tb/ow_temp_sequencer_tb_top.sv
`timescale 1ns/1ps
module ow_temp_sequencer_tb_top;
  localparam int CLK_HZ   = 4000;
  localparam int CONV_MS  = 750;
  localparam int WAIT_CYC = CLK_HZ / 1000 * CONV_MS;
  localparam int LAT      = 3;

  logic clk = 1'b0, rstN = 1'b0, startMeas = 1'b0, startId = 1'b0;
  logic busReq, busDone, busPresence, busy, done, valid, crcOk, present;
  logic [1:0]  busOp;
  logic [7:0]  busWrByte, busRdByte;
  logic [11:0] tempC;
  logic [63:0] romCode;

  int checks = 0, errors = 0, cyc = 0;
  int lastDoneCyc = 0, convDoneCyc = 0;
  bit convPending = 0;
  int expQ[$];
  logic [7:0] respQ[$];
  bit respPres = 1;
  logic [11:0] expTemp = '0;
  logic [63:0] expRom  = '0;

  always #2.5 clk = ~clk;

  ow_temp_sequencer #(.CLK_HZ(CLK_HZ), .CONV_MS(CONV_MS)) dut_i (
    .clk(clk), .rstN(rstN), .startMeas(startMeas), .startId(startId),
    .busReq(busReq), .busOp(busOp), .busWrByte(busWrByte), .busDone(busDone),
    .busRdByte(busRdByte), .busPresence(busPresence), .busy(busy), .done(done),
    .valid(valid), .crcOk(crcOk), .present(present), .tempC(tempC), .romCode(romCode)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crcRef(input logic [7:0] cIn, input logic [7:0] d);
    logic [7:0] c = cIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
      else c = c >> 1;
    end
    return c;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // bus engine model: compares every request against the expected command list
  initial begin
    busDone = 1'b0; busRdByte = '0; busPresence = 1'b0;
    forever begin
      @(negedge clk);
      busDone = 1'b0;
      if (busReq) begin
        int got, e;
        bit isConv, isRead;
        got = int'(busOp) * 256 + int'(busWrByte);
        if (expQ.size() == 0) check(0, "R3 extra request", got, -1);
        else begin
          e = expQ.pop_front();
          check(got == e, "R3 command order", got, e);
        end
        if (convPending) begin
          check(cyc - convDoneCyc == WAIT_CYC + 1, "R4 wait length", cyc - convDoneCyc, WAIT_CYC + 1);
          convPending = 0;
        end
        isConv = (got == 256 + 8'h44);
        isRead = (busOp == 2'd2);
        for (int i = 0; i < LAT; i++) begin
          @(negedge clk);
          check(!busReq, "R2 request while outstanding", busReq, 0);
        end
        busDone = 1'b1;
        busPresence = respPres;
        busRdByte = (isRead && respQ.size() > 0) ? respQ.pop_front() : 8'h00;
        lastDoneCyc = cyc;
        if (isConv) begin convPending = 1; convDoneCyc = cyc; end
      end
    end
  end

  task automatic runTxn(input bit meas, input bit pres, input logic [63:0] payload,
                        input bit bad, input int pokeAt, input bit both);
    logic [7:0] bytes[$];
    logic [7:0] c;
    int n, k;
    bit expOk;
    n = meas ? 8 : 7;
    bytes = {};
    c = 8'h00;
    for (int i = 0; i < n; i++) begin
      bytes.push_back(payload[8*i +: 8]);
      c = crcRef(c, payload[8*i +: 8]);
    end
    bytes.push_back(bad ? (c ^ 8'h01) : c);
    c = 8'h00;
    foreach (bytes[i]) c = crcRef(c, bytes[i]);
    expOk = pres && (c == 8'h00);
    expQ = {0};
    if (pres) begin
      if (meas) begin
        expQ.push_back(256 + 8'hCC); expQ.push_back(256 + 8'h44); expQ.push_back(0);
        expQ.push_back(256 + 8'hCC); expQ.push_back(256 + 8'hBE);
        for (int i = 0; i < 9; i++) expQ.push_back(512);
      end else begin
        expQ.push_back(256 + 8'h33);
        for (int i = 0; i < 8; i++) expQ.push_back(512);
      end
    end
    respQ = bytes;
    respPres = pres;
    if (pres && meas)  expTemp = 12'(($signed(payload[15:0])) >>> 4);
    if (pres && !meas) begin
      expRom = payload;
      expRom[63:56] = bytes[7];
    end
    @(negedge clk);
    startMeas = meas || both;
    startId   = !meas || both;
    @(negedge clk);
    startMeas = 0; startId = 0;
    check(busy == 1'b1, "R10 start accepted", busy, 1);
    k = 0;
    while (!done && k < 20000) begin
      startId   = (k == pokeAt);
      startMeas = (k == pokeAt);
      @(negedge clk);
      k++;
    end
    startId = 0; startMeas = 0;
    check(done == 1'b1, "R9 done raised", done, 1);
    check(cyc - lastDoneCyc == 2, "R9 done latency", cyc - lastDoneCyc, 2);
    check(present == pres, "R8 present flag", present, pres);
    check(crcOk == expOk, "R6 crc flag", crcOk, expOk);
    check(valid == expOk, "R9 valid flag", valid, expOk);
    check(tempC == expTemp, "R7 R11 temperature", tempC, expTemp);
    check(romCode == expRom, "R5 R11 identity code", romCode, expRom);
    check(expQ.size() == 0, "R3 R5 R8 commands missing", expQ.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done pulse width", done, 0);
    check(valid == expOk, "R9 flags held", valid, expOk);
    check(busy == 1'b0, "R10 back to idle", busy, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && busReq == 0, "R1 control reset", {busy, done, busReq}, 0);
    check(valid == 0 && crcOk == 0 && present == 0, "R1 flag reset", {valid, crcOk, present}, 0);
    check(tempC == 0 && romCode == 0, "R1 data reset", tempC, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R3 R4 R7: positive reading 25.06 C
    runTxn(1, 1, 64'h10_0C_FF_7F_46_4B_01_91, 0, -1, 0);
    // R7: negative reading keeps sign
    runTxn(1, 1, 64'h10_0C_FF_7F_46_4B_FF_5E, 0, -1, 0);
    // R5: identity read, good CRC
    runTxn(0, 1, 64'h00_A2_3C_5E_0F_11_04_28, 0, -1, 0);
    // R6: identity with corrupted CRC
    runTxn(0, 1, 64'h00_01_02_03_04_05_06_28, 1, -1, 0);
    // R6 R11: measurement with corrupted CRC
    runTxn(1, 1, 64'h10_0C_FF_7F_46_4B_00_50, 1, -1, 0);
    // R8: no presence on first reset
    runTxn(1, 0, 64'h10_0C_FF_7F_46_4B_07_D0, 0, -1, 0);
    runTxn(0, 0, 64'h00_11_22_33_44_55_66_28, 0, -1, 0);
    // R10: starts during a busy job are ignored
    runTxn(1, 1, 64'h10_0C_FF_7F_46_4B_00_A2, 0, 200, 0);
    runTxn(0, 1, 64'h00_9A_8B_7C_6D_5E_4F_28, 0, 4, 0);
    // R10: both starts together run a measurement
    runTxn(1, 1, 64'h10_0C_FF_7F_46_4B_FC_90, 0, -1, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule